// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

This block sits between a byte-wide processor port and a word-wide memory controller. It keeps recently used memory lines in a two-way set-associative store. Each line is eight memory words long. The line data lives in a dual-port RAM: one port serves processor bytes and the other moves whole words during line transfers. Tag, valid and dirty state is kept per way and per set, and each set has one least-recently-used bit.

A processor access that hits completes in a single clock and causes no memory traffic. On a miss the controller latches the request and raises busy. It then picks a victim way, preferring an invalid way and otherwise the least recently used one. A dirty victim is streamed out as an eight-word burst under a valid/ready handshake. Two idle clocks follow the burst, and then eight words are read in to refill the same way. A clean or invalid victim goes straight to the refill. When the refill is done, the pending processor byte is read from the new line, or written into it and the line marked dirty. Busy then drops.

Top module: `cache2w_ctrl`

## Requirements
- R1: After reset, cpu_busy, mem_wvalid and mem_rreq are all low, and every line is invalid.
- R2: An access that hits leaves cpu_busy low and starts no memory traffic. During the request cycle, hit_way shows the way that holds the line. A read returns its byte on cpu_rdata in the next cycle. A write stores its byte. Byte b of a word occupies bits 8*b+7 down to 8*b, so byte 0 is bits 7:0.
- R3: A miss raises cpu_busy from the cycle after the request until the access completes. For a read, cpu_rdata holds the requested byte once cpu_busy has fallen.
- R4: The victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way not most recently used in that set. Hits and refills both count as use. While cpu_busy is high, hit_way shows the victim way. Two valid ways of one set never hold the same tag.
- R5: Only a victim that is both valid and dirty is written back. A write-back is exactly eight words at word addresses {victim tag, set, 0..7}, in ascending order, and each word carries the line's current contents.
- R6: A write-back word transfers only on a clock where mem_wvalid and mem_wready are both high. While mem_wready is low, mem_addr and mem_wdata hold steady.
- R7: Exactly two clocks in which neither mem_wvalid nor mem_rreq is high separate the last write-back transfer from the first clock of mem_rreq.
- R8: A refill asserts mem_rreq and requests word addresses {request tag, set, 0..7} in ascending order. The address advances by one word on each clock where mem_rvalid is high, and mem_rdata from that clock is stored at that word.
- R9: After the refill, a pending write stores its byte at the requested byte offset in the new line and marks the line dirty. A later hit reads that byte back, and the other bytes of the line keep the refilled values.
- R10: mem_wvalid and mem_rreq are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, sampled when cpu_busy is low |
| cpu_we | input | 1 | 1 = write byte, 0 = read byte |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_rdata | output | 8 | Byte read, valid after the completing clock |
| cpu_busy | output | 1 | Miss in progress |
| hit_way | output | 1 | Hit way when idle, victim way while busy |
| mem_addr | output | ADDR_W-log2(WORD_BYTES) | Word address of the current burst beat |
| mem_wvalid | output | 1 | Write-back word offered |
| mem_wready | input | 1 | Memory accepts the offered word |
| mem_wdata | output | 8*WORD_BYTES | Write-back word |
| mem_rreq | output | 1 | Refill word requested at mem_addr |
| mem_rvalid | input | 1 | mem_rdata carries the requested word |
| mem_rdata | input | 8*WORD_BYTES | Refill word |

## Verification
The bench builds the block with its default parameters: 12-bit byte addresses, two-byte words, eight-word lines and four sets. This leaves a six-bit tag, so a few distinct tag values are enough to pile three lines onto one set and force a dirty eviction through the least-recently-used bit. A second set is then free for a clean-victim case that must produce no write-back. The small address space lets the bench keep a full byte-level reference image and a word-level memory model. Every write-back word and every byte read can then be compared, including while the memory stalls its ready and valid inputs.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_WBACK,
        ST_SETTLE,
        ST_REFILL,
        ST_FINISH
    } cstate_e;

    localparam int SETTLE_CYCLES = 2;

endpackage

// File: rtl/cache2w_dpram.sv
module cache2w_dpram #(
    parameter int DEPTH      = 64,
    parameter int WORD_BYTES = 2,
    parameter int IDX_W      = $clog2(DEPTH),
    parameter int BSEL_W     = $clog2(WORD_BYTES)
) (
    input  logic                    clk,
    input  logic                    a_re,
    input  logic                    a_we,
    input  logic [IDX_W-1:0]        a_idx,
    input  logic [BSEL_W-1:0]       a_bsel,
    input  logic [7:0]              a_wd,
    output logic [7:0]              a_q,
    input  logic                    b_we,
    input  logic [IDX_W-1:0]        b_idx,
    input  logic [8*WORD_BYTES-1:0] b_wd,
    output logic [8*WORD_BYTES-1:0] b_q
);

    logic [8*WORD_BYTES-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (b_we)
            store_q[b_idx] <= b_wd;
        if (a_we)
            store_q[a_idx][{a_bsel, 3'b000} +: 8] <= a_wd;
        if (a_re)
            a_q <= store_q[a_idx][{a_bsel, 3'b000} +: 8];
        b_q <= store_q[b_idx];
    end

endmodule

// File: rtl/cache2w_tags.sv
module cache2w_tags #(
    parameter int SETS  = 4,
    parameter int TAG_W = 6,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_hway,
    output logic             lk_vway,
    output logic             lk_vdirty,
    output logic [TAG_W-1:0] lk_vtag,
    input  logic [SET_W-1:0] up_set,
    input  logic             up_way,
    input  logic [TAG_W-1:0] up_tag,
    input  logic             up_fill,
    input  logic             up_dirty,
    input  logic             up_touch
);

    logic [1:0]       w_hit, w_vld, w_dty;
    logic [TAG_W-1:0] w_tag [2];
    logic [SETS-1:0]  lru_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]  vld_q, dty_q;
        logic [TAG_W-1:0] tag_q [SETS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
                dty_q <= '0;
            end else if (up_way == 1'(w)) begin
                if (up_fill) begin
                    vld_q[up_set] <= 1'b1;
                    dty_q[up_set] <= 1'b0;
                end
                if (up_dirty)
                    dty_q[up_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (up_fill && up_way == 1'(w))
                tag_q[up_set] <= up_tag;
        end

        assign w_vld[w] = vld_q[lk_set];
        assign w_dty[w] = dty_q[lk_set];
        assign w_tag[w] = tag_q[lk_set];
        assign w_hit[w] = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            lru_q <= '0;
        else if (up_touch)
            lru_q[up_set] <= ~up_way;
    end

    always_comb begin
        lk_hit  = |w_hit;
        lk_hway = w_hit[1];
        if (!w_vld[0])
            lk_vway = 1'b0;
        else if (!w_vld[1])
            lk_vway = 1'b1;
        else
            lk_vway = lru_q[lk_set];
        lk_vdirty = w_vld[lk_vway] && w_dty[lk_vway];
        lk_vtag   = w_tag[lk_vway];
    end

    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(w_hit)); // R4

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WORD_BYTES = 2,
    parameter int LINE_WORDS = 8,
    parameter int SETS       = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    cpu_req,
    input  logic                                    cpu_we,
    input  logic [ADDR_W-1:0]                       cpu_addr,
    input  logic [7:0]                              cpu_wdata,
    output logic [7:0]                              cpu_rdata,
    output logic                                    cpu_busy,
    output logic                                    hit_way,
    output logic [ADDR_W-$clog2(WORD_BYTES)-1:0]    mem_addr,
    output logic                                    mem_wvalid,
    input  logic                                    mem_wready,
    output logic [8*WORD_BYTES-1:0]                 mem_wdata,
    output logic                                    mem_rreq,
    input  logic                                    mem_rvalid,
    input  logic [8*WORD_BYTES-1:0]                 mem_rdata
);

    localparam int WORD_W    = 8 * WORD_BYTES;
    localparam int BSEL_W    = $clog2(WORD_BYTES);
    localparam int WOFS_W    = $clog2(LINE_WORDS);
    localparam int SET_W     = $clog2(SETS);
    localparam int TAG_W     = ADDR_W - BSEL_W - WOFS_W - SET_W;
    localparam int RAM_DEPTH = 2 * SETS * LINE_WORDS;
    localparam int RIDX_W    = $clog2(RAM_DEPTH);
    localparam logic [WOFS_W-1:0] LAST_WORD  = WOFS_W'(LINE_WORDS - 1);
    localparam logic [WOFS_W-1:0] LAST_QUIET = WOFS_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        cstate_e           st;
        logic [WOFS_W-1:0] cnt;
        logic              way;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdat;
        logic [TAG_W-1:0]  vtag;
    } ctl_t;

    ctl_t r_q, r_d;

    // request field split
    logic [SET_W-1:0]  c_set, q_set;
    logic [TAG_W-1:0]  c_tag, q_tag;
    logic [WOFS_W-1:0] c_wofs, q_wofs;
    logic [BSEL_W-1:0] c_bsel, q_bsel;

    assign c_bsel = cpu_addr[BSEL_W-1:0];
    assign c_wofs = cpu_addr[BSEL_W +: WOFS_W];
    assign c_set  = cpu_addr[BSEL_W+WOFS_W +: SET_W];
    assign c_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign q_bsel = r_q.addr[BSEL_W-1:0];
    assign q_wofs = r_q.addr[BSEL_W +: WOFS_W];
    assign q_set  = r_q.addr[BSEL_W+WOFS_W +: SET_W];
    assign q_tag  = r_q.addr[ADDR_W-1 -: TAG_W];

    logic             lk_hit, lk_hway, lk_vway, lk_vdirty;
    logic [TAG_W-1:0] lk_vtag;
    logic [SET_W-1:0] m_set;
    logic             m_way, m_fill, m_dirty, m_touch;

    logic              a_re, a_we, b_we;
    logic [RIDX_W-1:0] a_idx, b_idx;
    logic [BSEL_W-1:0] a_bsel;
    logic [7:0]        a_wd;
    logic [WORD_W-1:0] b_q;

    always_comb begin
        r_d     = r_q;
        a_re    = 1'b0;
        a_we    = 1'b0;
        a_idx   = {r_q.way, q_set, q_wofs};
        a_bsel  = q_bsel;
        a_wd    = r_q.wdat;
        b_we    = 1'b0;
        m_set   = q_set;
        m_way   = r_q.way;
        m_fill  = 1'b0;
        m_dirty = 1'b0;
        m_touch = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cpu_req && lk_hit) begin
                    a_idx   = {lk_hway, c_set, c_wofs};
                    a_bsel  = c_bsel;
                    a_wd    = cpu_wdata;
                    a_we    = cpu_we;
                    a_re    = !cpu_we;
                    m_set   = c_set;
                    m_way   = lk_hway;
                    m_dirty = cpu_we;
                    m_touch = 1'b1;
                end else if (cpu_req) begin
                    r_d.st   = lk_vdirty ? ST_PRIME : ST_REFILL;
                    r_d.cnt  = '0;
                    r_d.way  = lk_vway;
                    r_d.vtag = lk_vtag;
                    r_d.we   = cpu_we;
                    r_d.addr = cpu_addr;
                    r_d.wdat = cpu_wdata;
                end
            end
            ST_PRIME: r_d.st = ST_WBACK;
            ST_WBACK: begin
                if (mem_wready) begin
                    r_d.cnt = r_q.cnt + WOFS_W'(1);
                    if (r_q.cnt == LAST_WORD) begin
                        r_d.st  = ST_SETTLE;
                        r_d.cnt = '0;
                    end
                end
            end
            ST_SETTLE: begin
                r_d.cnt = r_q.cnt + WOFS_W'(1);
                if (r_q.cnt == LAST_QUIET) begin
                    r_d.st  = ST_REFILL;
                    r_d.cnt = '0;
                end
            end
            ST_REFILL: begin
                if (mem_rvalid) begin
                    b_we    = 1'b1;
                    r_d.cnt = r_q.cnt + WOFS_W'(1);
                    if (r_q.cnt == LAST_WORD) begin
                        r_d.st  = ST_FINISH;
                        r_d.cnt = '0;
                        m_fill  = 1'b1;
                        m_touch = 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                a_we    = r_q.we;
                a_re    = !r_q.we;
                m_dirty = r_q.we;
                m_touch = 1'b1;
                r_d.st  = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        // refill writes the current beat; write-back prefetches the next one
        b_idx = (r_q.st == ST_REFILL) ? {r_q.way, q_set, r_q.cnt}
                                      : {r_q.way, q_set, r_d.cnt};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    cache2w_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(c_set), .lk_tag(c_tag),
        .lk_hit(lk_hit), .lk_hway(lk_hway), .lk_vway(lk_vway),
        .lk_vdirty(lk_vdirty), .lk_vtag(lk_vtag),
        .up_set(m_set), .up_way(m_way), .up_tag(q_tag),
        .up_fill(m_fill), .up_dirty(m_dirty), .up_touch(m_touch)
    );

    cache2w_dpram #(.DEPTH(RAM_DEPTH), .WORD_BYTES(WORD_BYTES)) u_ram (
        .clk(clk),
        .a_re(a_re), .a_we(a_we), .a_idx(a_idx), .a_bsel(a_bsel),
        .a_wd(a_wd), .a_q(cpu_rdata),
        .b_we(b_we), .b_idx(b_idx), .b_wd(mem_rdata), .b_q(b_q)
    );

    assign cpu_busy   = (r_q.st != ST_IDLE);
    assign hit_way    = cpu_busy ? r_q.way : lk_hway;
    assign mem_wvalid = (r_q.st == ST_WBACK);
    assign mem_rreq   = (r_q.st == ST_REFILL);
    assign mem_wdata  = b_q;
    assign mem_addr   = (r_q.st == ST_REFILL) ? {q_tag, q_set, r_q.cnt}
                                              : {r_q.vtag, q_set, r_q.cnt};

    AST_HIT_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_busy && cpu_req && lk_hit) |=> (!cpu_busy && !mem_wvalid && !mem_rreq)); // R2

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_addr) && $stable(mem_wdata))); // R6

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wvalid) |-> (!mem_rreq ##1 !mem_rreq ##1 mem_rreq)); // R7

    AST_RD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rreq && mem_rvalid && mem_addr[WOFS_W-1:0] != LAST_WORD)
        |=> (mem_rreq && mem_addr[WOFS_W-1:0] == $past(mem_addr[WOFS_W-1:0]) + WOFS_W'(1))); // R8

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wvalid && mem_rreq)); // R10

endmodule

// File: tb/sim_cache2w_ctrl.sv
module sim_cache2w_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_busy, hit_way;
    logic [10:0] mem_addr;
    logic        mem_wvalid, mem_rreq;
    logic        mem_wready = 1'b0, mem_rvalid = 1'b0;
    logic [15:0] mem_wdata, mem_rdata = '0;

    always #10 clk = ~clk;

    cache2w_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy),
        .hit_way(hit_way), .mem_addr(mem_addr), .mem_wvalid(mem_wvalid),
        .mem_wready(mem_wready), .mem_wdata(mem_wdata), .mem_rreq(mem_rreq),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int checks = 0, fails = 0, cyc = 0;
    int wb_beats = 0, rd_beats = 0, last_wb = 0;
    bit stall = 0, wb_done = 0, wv_prev = 0, rr_prev = 0, finished = 0;
    logic [10:0] wb_base = '0, rd_base = '0;
    logic [15:0] model [2048];
    logic [7:0]  golden [4096];

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input int tag, input int set, input int wofs, input int b);
        return {6'(tag), 2'(set), 3'(wofs), 1'(b)};
    endfunction

    // memory side responder
    initial begin
        for (int i = 0; i < 2048; i++) begin
            model[i] = 16'(i * 16'h0105) ^ 16'h3C5A;
            golden[2*i]   = model[i][7:0];
            golden[2*i+1] = model[i][15:8];
        end
        forever begin
            @(negedge clk);
            cyc++;
            mem_wready = !stall || (cyc % 3 != 1);
            mem_rvalid = 1'b0;
            if (mem_wvalid) begin
                if (!wv_prev) wb_base = mem_addr;
                if (mem_wready) begin
                    chk(mem_addr[2:0] == 3'(wb_beats % 8), "R5 write-back order", 32'(mem_addr), 32'(wb_beats % 8));
                    chk(mem_wdata == {golden[{mem_addr, 1'b1}], golden[{mem_addr, 1'b0}]},
                        "R5 write-back data", 32'(mem_wdata),
                        32'({golden[{mem_addr, 1'b1}], golden[{mem_addr, 1'b0}]}));
                    model[mem_addr] = mem_wdata;
                    wb_beats++;
                    if (wb_beats % 8 == 0) begin
                        wb_done = 1;
                        last_wb = cyc;
                    end
                end
            end
            if (mem_rreq) begin
                if (!rr_prev) begin
                    rd_base = mem_addr;
                    if (wb_done) begin
                        chk(cyc - last_wb == 3, "R7 settle gap", 32'(cyc - last_wb), 32'd3);
                        wb_done = 0;
                    end
                end
                if (!stall || (cyc % 4 != 2)) begin
                    chk(mem_addr[2:0] == 3'(rd_beats % 8), "R8 refill order", 32'(mem_addr), 32'(rd_beats % 8));
                    mem_rdata  = model[mem_addr];
                    mem_rvalid = 1'b1;
                    rd_beats++;
                end
            end
            chk(!(mem_wvalid && mem_rreq), "R10 one direction", 32'({mem_wvalid, mem_rreq}), 32'd0);
            wv_prev = mem_wvalid;
            rr_prev = mem_rreq;
        end
    end

    task automatic access(input logic we, input logic [11:0] a, input logic [7:0] wd,
                          input bit exp_hit, input logic exp_way, input bit exp_wb,
                          input logic [10:0] exp_wbase, input string r);
        int wb0, rd0, guard;
        @(negedge clk);
        #1;
        wb0 = wb_beats; rd0 = rd_beats;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        if (exp_hit)
            chk(hit_way == exp_way, {r, " hit way"}, 32'(hit_way), 32'(exp_way));
        @(negedge clk);
        cpu_req = 1'b0;
        if (exp_hit) begin
            chk(!cpu_busy, {r, " busy on hit"}, 32'(cpu_busy), 32'd0);
            chk(wb_beats == wb0 && rd_beats == rd0 && !mem_wvalid && !mem_rreq,
                {r, " traffic on hit"}, 32'(wb_beats - wb0 + rd_beats - rd0), 32'd0);
        end else begin
            chk(cpu_busy, {r, " busy on miss"}, 32'(cpu_busy), 32'd1);
            chk(hit_way == exp_way, {r, " victim way"}, 32'(hit_way), 32'(exp_way));
            guard = 0;
            while (cpu_busy && guard < 2000) begin
                @(negedge clk);
                guard++;
            end
            chk(!cpu_busy, {r, " miss completes"}, 32'(cpu_busy), 32'd0);
            chk(rd_beats - rd0 == 8, {r, " refill beats"}, 32'(rd_beats - rd0), 32'd8);
            chk(rd_base == {a[11:4], 3'b000}, {r, " refill base"}, 32'(rd_base), 32'({a[11:4], 3'b000}));
            chk(wb_beats - wb0 == (exp_wb ? 8 : 0), {r, " write-back beats"},
                32'(wb_beats - wb0), exp_wb ? 32'd8 : 32'd0);
            if (exp_wb)
                chk(wb_base == exp_wbase, {r, " write-back base"}, 32'(wb_base), 32'(exp_wbase));
        end
        if (!we)
            chk(cpu_rdata == golden[a], {r, " read byte"}, 32'(cpu_rdata), 32'(golden[a]));
        else
            golden[a] = wd;
    endtask

    task automatic t_reset;
        chk(!cpu_busy && !mem_wvalid && !mem_rreq, "R1 reset outputs",
            32'({cpu_busy, mem_wvalid, mem_rreq}), 32'd0);
    endtask

    task automatic t_cold_and_hits;
        access(0, mk(1, 0, 3, 1), 8'h00, 0, 1'b0, 0, '0, "R3/R4 cold read miss");
        access(0, mk(1, 0, 5, 0), 8'h00, 1, 1'b0, 0, '0, "R2 read hit");
        access(1, mk(1, 0, 2, 1), 8'hA5, 1, 1'b0, 0, '0, "R2 write hit");
        access(0, mk(1, 0, 2, 1), 8'h00, 1, 1'b0, 0, '0, "R2 read back");
        access(0, mk(1, 0, 2, 0), 8'h00, 1, 1'b0, 0, '0, "R2 neighbour byte");
    endtask

    task automatic t_dirty_evict;
        access(0, mk(2, 0, 0, 0), 8'h00, 0, 1'b1, 0, '0, "R4 invalid way preferred");
        access(1, mk(2, 0, 7, 0), 8'h3C, 1, 1'b1, 0, '0, "R2 write hit way 1");
        access(0, mk(1, 0, 2, 1), 8'h00, 1, 1'b0, 0, '0, "R4 touch way 0");
        stall = 1;
        access(1, mk(3, 0, 4, 1), 8'h77, 0, 1'b1, 1, {6'd2, 2'd0, 3'd0}, "R5/R6/R7 dirty victim under stall");
        stall = 0;
        access(0, mk(3, 0, 4, 1), 8'h00, 1, 1'b1, 0, '0, "R9 merged byte");
        access(0, mk(3, 0, 4, 0), 8'h00, 1, 1'b1, 0, '0, "R9 other byte refilled");
    endtask

    task automatic t_clean_evict;
        access(0, mk(4, 1, 1, 0), 8'h00, 0, 1'b0, 0, '0, "R4 set 1 fill way 0");
        access(0, mk(5, 1, 6, 1), 8'h00, 0, 1'b1, 0, '0, "R4 set 1 fill way 1");
        access(0, mk(6, 1, 0, 1), 8'h00, 0, 1'b0, 0, '0, "R5 clean victim skips write-back");
    endtask

    task automatic t_writeback_content;
        access(0, mk(2, 0, 7, 0), 8'h00, 0, 1'b0, 1, {6'd1, 2'd0, 3'd0}, "R5/R8 refill sees written-back byte");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset;
        t_cold_and_hits;
        t_dirty_evict;
        t_clean_evict;
        t_writeback_content;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule